// File: doc/BRIEF.md
# Multi-Mode Host Bus Interface

This block is the host-facing front end of a display controller. A host processor reaches it over one of three ports, chosen by strap inputs that stay fixed during operation: a parallel bus with separate active-low read and write strobes (8080 style), a parallel bus with an active-high enable and a read/write direction line (6800 style), or a write-only serial link. The serial link has a 4-line variant, in which the command/data flag comes from the register-select pin. It also has a 3-line variant, in which the flag travels in the frame as an extra leading bit.

Every host pin passes through a two-flop synchronizer into the core clock. Strobe edges are found on the synchronized copies. The pin values from the sample just before the edge are used to build a transfer. Each accepted write appears at the core side as a single-cycle valid pulse carrying a 16-bit word and a flag that says whether the word is display data or an instruction. On parallel reads, the block drives the core's read word onto the host data bus only while the read is active.

Top module: `host_bus_front`

## Requirements
- R1: While reset is held and on the first cycle after it, `wd_valid` is 0, `wd_word` is 0, `wd_is_data` is 0 and `bus_oe` is 0 (with `cs_n` high).
- R2: In 8080 style (`strap_par`=1, `strap_m68`=0), a low-to-high transition of `wr_n_rw` while `cs_n` is low produces one `wd_valid` pulse within 4 core cycles. The pulse carries the bus word present just before the transition.
- R3: In 6800 style (`strap_par`=1, `strap_m68`=1), a high-to-low transition of the enable `rd_n_e` while `wr_n_rw` is low (write) and `cs_n` is low produces one `wd_valid` pulse carrying the bus word present just before the transition.
- R4: While `cs_n` is high, strobes, enables and serial clocks produce no word, and `bus_oe` stays 0.
- R5: For parallel and 4-line serial writes, `wd_is_data` equals the level of `rs` at the transfer: 1 marks display data and 0 marks an instruction.
- R6: With `strap_wide`=1 a parallel word is all 16 bus lines. With `strap_wide`=0 it is `{8'h00, bus_in[7:0]}`, and `bus_in[15:8]` has no effect.
- R7: 4-line serial (`strap_par`=0, `strap_ser4`=1): `bus_in[7]` is sampled on each rising edge of the shift clock `bus_in[6]`, most significant bit first. The 8th bit completes a word `{8'h00, byte}`, with the flag taken from `rs` at that 8th edge. `bus_in[15:8]` and `bus_in[5:0]` have no effect.
- R8: 3-line serial (`strap_ser4`=0): frames are 9 bits. The first bit is the data/instruction flag and the next 8 are the byte, most significant bit first. `rs` has no effect.
- R9: Raising `cs_n` in the middle of a serial frame discards the bits received so far. The next frame starts from its first bit.
- R10: `bus_oe` is 1 and `bus_out` equals `rd_data` exactly when `strap_par`=1, `cs_n`=0, and either (8080) `rd_n_e`=0 or (6800) `rd_n_e`=1 with `wr_n_rw`=1. In serial mode `bus_oe` is always 0.
- R11: `wd_valid` lasts one cycle per transfer. `wd_word` and `wd_is_data` hold their last value between pulses.
- R12: A read cycle produces no `wd_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_par | input | 1 | 1 selects a parallel bus, 0 the serial link |
| strap_m68 | input | 1 | Parallel style: 1 enable plus direction, 0 separate strobes |
| strap_wide | input | 1 | Parallel width: 1 sixteen lines, 0 eight lines |
| strap_ser4 | input | 1 | Serial variant: 1 flag from `rs`, 0 flag as leading bit |
| cs_n | input | 1 | Chip select, active low |
| rs | input | 1 | Register select: 1 data, 0 instruction |
| rd_n_e | input | 1 | Read strobe (active low) or enable (active high) |
| wr_n_rw | input | 1 | Write strobe (active low) or direction (1 read, 0 write) |
| bus_in | input | 16 | Host data lines as seen at the pads; bit 7 serial data, bit 6 shift clock |
| rd_data | input | 16 | Word to return on a host read |
| bus_out | output | 16 | Data driven toward the host pads |
| bus_oe | output | 1 | Pad output enable; 0 means released |
| wd_valid | output | 1 | One-cycle pulse for each accepted write |
| wd_is_data | output | 1 | 1 display data, 0 instruction |
| wd_word | output | 16 | Normalized written word |

## Verification
The assertions rely on the host holding each strobe, enable and shift-clock phase for at least two core cycles, so that two accepted writes can never fall on adjacent cycles. They also rely on the straps staying constant outside reset. The stimulus keeps every phase three or more cycles long, holds data and register select steady around each edge, and changes straps only while reset is asserted. The bench model derives the expected words from the pin sequences it drives and checks the output enable against the pin levels on every cycle.

// File: rtl/hbf_pkg.sv
// Shared width and transfer type for the host bus front end.
// Assumes a 16-bit normalized word whose lower half is one byte lane.
package hbf_pkg;
    localparam int HBF_W    = 16;
    localparam int HBF_BYTE = HBF_W / 2;

    // One accepted write as presented to the core
    typedef struct packed {
        logic             is_data;
        logic [HBF_W-1:0] word;
    } hbf_xfer_t;
endpackage

// File: rtl/hbf_pin_sync.sv
// Level synchronizer: three flops per pin. The output is the oldest stage.
// Its depth matches the "previous" tap of hbf_strobe_sync, so levels
// line up with the sample taken just before a detected strobe edge.
// Assumes asynchronous pins; reset preloads every stage from the pin.
module hbf_pin_sync #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] lvl_o
);
    localparam int DEPTH = 3;

    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [DEPTH-1:0] st;

        // shift the pin through the synchronizer chain
        always_ff @(posedge clk) begin
            if (!rst_n) st <= {DEPTH{pin_i[g]}};
            else        st <= {st[DEPTH-2:0], pin_i[g]};
        end

        assign lvl_o[g] = st[DEPTH-1];
    end
endmodule

// File: rtl/hbf_strobe_sync.sv
// Strobe synchronizer: three flops per pin with two taps. cur_o is the
// newest synchronized value and prev_o is the one before it, so an edge
// is cur_o != prev_o. Reset preloads from the pin, so no edge appears
// when reset is released.
module hbf_strobe_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] cur_o,
    output logic [W-1:0] prev_o
);
    localparam int DEPTH = 3;

    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [DEPTH-1:0] st;

        // shift the strobe through the synchronizer chain
        always_ff @(posedge clk) begin
            if (!rst_n) st <= {DEPTH{pin_i[g]}};
            else        st <= {st[DEPTH-2:0], pin_i[g]};
        end

        assign cur_o[g]  = st[DEPTH-2];
        assign prev_o[g] = st[DEPTH-1];
    end
endmodule

// File: rtl/hbf_par_capture.sv
// Parallel write detector for both bus styles. It works on synchronized
// strobes and uses the levels sampled just before the edge.
// 8080 style: write strobe rising. 6800 style: enable falling while the
// direction line says write. Combinational; the top registers the result.
module hbf_par_capture
    import hbf_pkg::*;
#(
    parameter int DATA_W = HBF_W,
    parameter int BYTE_W = DATA_W / 2
) (
    input  logic              en_i,
    input  logic              m68_i,
    input  logic              wide_i,
    input  logic              cs_n_i,
    input  logic              rs_i,
    input  logic              wr_cur_i,
    input  logic              wr_prev_i,
    input  logic              e_cur_i,
    input  logic              e_prev_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              hit_o,
    output hbf_xfer_t         xfer_o
);
    logic wr80_edge;
    logic wr68_edge;

    // detect the closing edge of a write in each style
    always_comb begin
        wr80_edge = !m68_i && wr_cur_i && !wr_prev_i;
        wr68_edge = m68_i && !e_cur_i && e_prev_i && !wr_prev_i;
        hit_o     = en_i && !cs_n_i && (wr80_edge || wr68_edge);
    end

    // normalize the word to the selected bus width
    always_comb begin
        xfer_o.is_data = rs_i;
        if (wide_i) xfer_o.word = data_i;
        else        xfer_o.word = {{(DATA_W-BYTE_W){1'b0}}, data_i[BYTE_W-1:0]};
    end
endmodule

// File: rtl/hbf_ser_shift.sv
// Write-only serial receiver. Bits enter MSB first on rising shift-clock
// edges. 4-line: 8-bit frames, flag from register select at the last
// bit. 3-line: 9-bit frames whose leading bit is the flag.
// A deasserted chip select clears the partial frame.
module hbf_ser_shift
    import hbf_pkg::*;
#(
    parameter int DATA_W = HBF_W,
    parameter int BYTE_W = DATA_W / 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en_i,
    input  logic      four_line_i,
    input  logic      cs_n_i,
    input  logic      rs_i,
    input  logic      sck_cur_i,
    input  logic      sck_prev_i,
    input  logic      sdi_i,
    output logic      hit_o,
    output hbf_xfer_t xfer_o
);
    localparam int CNT_W = $clog2(BYTE_W + 2);

    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-2:0] shreg;
    logic              flag_q;
    logic              step;
    logic              last_bit;

    // qualify a shift-clock rising edge and spot the frame's last bit
    always_comb begin
        step     = en_i && !cs_n_i && sck_cur_i && !sck_prev_i;
        last_bit = four_line_i ? (bit_cnt == CNT_W'(BYTE_W - 1))
                               : (bit_cnt == CNT_W'(BYTE_W));
        hit_o    = step && last_bit;
    end

    // shift register, bit counter and leading-flag capture
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i || cs_n_i) begin
            bit_cnt <= '0;
            shreg   <= '0;
            flag_q  <= 1'b0;
        end else if (step) begin
            shreg <= {shreg[BYTE_W-3:0], sdi_i};
            if (!four_line_i && bit_cnt == '0) flag_q <= sdi_i;
            bit_cnt <= last_bit ? '0 : bit_cnt + 1'b1;
        end
    end

    // assemble the completed byte with the incoming last bit
    always_comb begin
        xfer_o.word    = {{(DATA_W-BYTE_W){1'b0}}, shreg, sdi_i};
        xfer_o.is_data = four_line_i ? rs_i : flag_q;
    end
endmodule

// File: rtl/host_bus_front.sv
// Host bus front end: synchronizes host pins, detects parallel (8080 or
// 6800 style) or serial writes, registers one normalized word per write,
// and drives read data back during parallel reads.
// Assumes straps are static outside reset, and that every strobe phase
// spans at least two core cycles.
module host_bus_front
    import hbf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strap_par,
    input  logic             strap_m68,
    input  logic             strap_wide,
    input  logic             strap_ser4,
    input  logic             cs_n,
    input  logic             rs,
    input  logic             rd_n_e,
    input  logic             wr_n_rw,
    input  logic [HBF_W-1:0] bus_in,
    input  logic [HBF_W-1:0] rd_data,
    output logic [HBF_W-1:0] bus_out,
    output logic             bus_oe,
    output logic             wd_valid,
    output logic             wd_is_data,
    output logic [HBF_W-1:0] wd_word
);
    localparam int LVL_W   = HBF_W + 2;
    localparam int L_RS    = HBF_W;
    localparam int L_CS    = HBF_W + 1;
    localparam int STB_W   = 3;
    localparam int S_WR    = 0;
    localparam int S_EN    = 1;
    localparam int S_SCK   = 2;
    localparam int SDI_BIT = 7;
    localparam int SCK_BIT = 6;

    logic [LVL_W-1:0] lvl;
    logic [STB_W-1:0] stb_cur;
    logic [STB_W-1:0] stb_prev;
    logic             par_hit;
    logic             ser_hit;
    hbf_xfer_t        par_xfer;
    hbf_xfer_t        ser_xfer;
    hbf_xfer_t        out_q;
    logic             valid_q;

    hbf_pin_sync #(.W(LVL_W)) lvl_sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i ({cs_n, rs, bus_in}),
        .lvl_o (lvl)
    );

    hbf_strobe_sync #(.W(STB_W)) stb_sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  ({bus_in[SCK_BIT], rd_n_e, wr_n_rw}),
        .cur_o  (stb_cur),
        .prev_o (stb_prev)
    );

    hbf_par_capture #(.DATA_W(HBF_W)) par_i (
        .en_i      (strap_par),
        .m68_i     (strap_m68),
        .wide_i    (strap_wide),
        .cs_n_i    (lvl[L_CS]),
        .rs_i      (lvl[L_RS]),
        .wr_cur_i  (stb_cur[S_WR]),
        .wr_prev_i (stb_prev[S_WR]),
        .e_cur_i   (stb_cur[S_EN]),
        .e_prev_i  (stb_prev[S_EN]),
        .data_i    (lvl[HBF_W-1:0]),
        .hit_o     (par_hit),
        .xfer_o    (par_xfer)
    );

    hbf_ser_shift #(.DATA_W(HBF_W)) ser_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (!strap_par),
        .four_line_i (strap_ser4),
        .cs_n_i      (lvl[L_CS]),
        .rs_i        (lvl[L_RS]),
        .sck_cur_i   (stb_cur[S_SCK]),
        .sck_prev_i  (stb_prev[S_SCK]),
        .sdi_i       (lvl[SDI_BIT]),
        .hit_o       (ser_hit),
        .xfer_o      (ser_xfer)
    );

    // register the accepted write and hold it until the next one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            out_q   <= '0;
        end else begin
            valid_q <= par_hit || ser_hit;
            if (par_hit)      out_q <= par_xfer;
            else if (ser_hit) out_q <= ser_xfer;
        end
    end

    // drive read data only while a parallel read is active at the pins
    always_comb begin
        if (strap_m68) bus_oe = strap_par && !cs_n && rd_n_e && wr_n_rw;
        else           bus_oe = strap_par && !cs_n && !rd_n_e;
        bus_out = bus_oe ? rd_data : '0;
    end

    assign wd_valid   = valid_q;
    assign wd_is_data = out_q.is_data;
    assign wd_word    = out_q.word;
endmodule

// File: rtl/hbf_checks.sv
// Assertion checker for host_bus_front, attached with bind below.
// Assumes strobe phases of two or more core cycles and static straps.
module hbf_checks (
    input logic        clk,
    input logic        rst_n,
    input logic        strap_par,
    input logic        strap_wide,
    input logic        wd_valid,
    input logic        wd_is_data,
    input logic [15:0] wd_word
);
    AST_ONE_CYCLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wd_valid |=> !wd_valid); // R11

    AST_SERIAL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_valid && !strap_par) |-> (wd_word[15:8] == 8'h00)); // R7

    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_valid && strap_par && !strap_wide) |-> (wd_word[15:8] == 8'h00)); // R6

    AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wd_valid && $past(rst_n)) |-> ($stable(wd_word) && $stable(wd_is_data))); // R11
endmodule

bind host_bus_front hbf_checks chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .strap_par  (strap_par),
    .strap_wide (strap_wide),
    .wd_valid   (wd_valid),
    .wd_is_data (wd_is_data),
    .wd_word    (wd_word)
);

// File: tb/host_bus_front_tb.sv
// Bench for host_bus_front: a queue-based model of expected writes,
// compared every clock, plus a per-cycle model of the output enable.
module host_bus_front_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_par = 1'b1, strap_m68 = 1'b0, strap_wide = 1'b1, strap_ser4 = 1'b1;
    logic        cs_n = 1'b1, rs = 1'b0, rd_n_e = 1'b1, wr_n_rw = 1'b1;
    logic [15:0] bus_in = 16'h0000;
    logic [15:0] rd_data = 16'h0000;
    logic [15:0] bus_out;
    logic        bus_oe, wd_valid, wd_is_data;
    logic [15:0] wd_word;

    int checks = 0;
    int failures = 0;
    logic [16:0] exp_q[$];
    logic [16:0] last_seen = '0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    host_bus_front dut_i (
        .clk(clk), .rst_n(rst_n), .strap_par(strap_par), .strap_m68(strap_m68),
        .strap_wide(strap_wide), .strap_ser4(strap_ser4), .cs_n(cs_n), .rs(rs),
        .rd_n_e(rd_n_e), .wr_n_rw(wr_n_rw), .bus_in(bus_in), .rd_data(rd_data),
        .bus_out(bus_out), .bus_oe(bus_oe), .wd_valid(wd_valid),
        .wd_is_data(wd_is_data), .wd_word(wd_word)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-clock comparison of outputs with the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit exp_oe;
            exp_oe = strap_par && !cs_n && (strap_m68 ? (rd_n_e && wr_n_rw) : !rd_n_e);
            check(bus_oe == exp_oe, "R10 bus_oe", bus_oe, exp_oe);
            if (exp_oe) check(bus_out == rd_data, "R10 bus_out", bus_out, rd_data);
            if (wd_valid) begin
                if (exp_q.size() == 0) begin
                    check(0, "R11/R12 unexpected word", {wd_is_data, wd_word}, 0);
                end else begin
                    logic [16:0] e;
                    e = exp_q.pop_front();
                    check({wd_is_data, wd_word} == e, "R2/R3/R5/R6/R7/R8 word", {wd_is_data, wd_word}, e);
                    last_seen = e;
                end
            end
        end
    end

    // watchdog: an expired run counts as a failure and still reports
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=done", WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic drained(input string tag);
        check(exp_q.size() == 0, tag, exp_q.size(), 0);
        check({wd_is_data, wd_word} == last_seen && !wd_valid, "R11 hold", {wd_is_data, wd_word}, last_seen);
    endtask

    task automatic do_reset(input logic par, input logic m68, input logic wide, input logic s4);
        rst_n = 1'b0;
        strap_par = par; strap_m68 = m68; strap_wide = wide; strap_ser4 = s4;
        cs_n = 1'b1; rs = 1'b0; bus_in = 16'h0000;
        rd_n_e = m68 ? 1'b0 : 1'b1;
        wr_n_rw = 1'b1;
        tick(5);
        check(!wd_valid && wd_word == 0 && !wd_is_data && !bus_oe, "R1 in reset", {wd_valid, wd_word}, 0);
        rst_n = 1'b1;
        last_seen = '0;
        tick(1);
        check(!wd_valid && wd_word == 0 && !wd_is_data && !bus_oe, "R1 after reset", {wd_valid, wd_word}, 0);
    endtask

    task automatic wr80(input logic rsv, input logic [15:0] d, input bit sel, input string tag);
        cs_n = !sel; rs = rsv; bus_in = d;
        tick(3);
        wr_n_rw = 1'b0;
        tick(4);
        if (sel) exp_q.push_back({rsv, strap_wide ? d : {8'h00, d[7:0]}});
        wr_n_rw = 1'b1;
        tick(3);
        cs_n = 1'b1; bus_in = 16'h5A3C;
        tick(8);
        drained(tag);
    endtask

    task automatic wr68(input logic rsv, input logic [15:0] d, input bit sel, input string tag);
        cs_n = !sel; rs = rsv; bus_in = d; wr_n_rw = 1'b0;
        tick(3);
        rd_n_e = 1'b1;
        tick(4);
        if (sel) exp_q.push_back({rsv, strap_wide ? d : {8'h00, d[7:0]}});
        rd_n_e = 1'b0;
        tick(3);
        wr_n_rw = 1'b1; cs_n = 1'b1; bus_in = 16'hC3A5;
        tick(8);
        drained(tag);
    endtask

    task automatic host_read(input logic [15:0] v, input bit sel, input string tag);
        rd_data = v; cs_n = !sel;
        tick(2);
        if (strap_m68) rd_n_e = 1'b1; else rd_n_e = 1'b0;
        tick(3);
        if (sel && strap_par) check(bus_oe && bus_out == v, tag, bus_out, v);
        else                  check(!bus_oe, tag, bus_oe, 0);
        if (strap_m68) rd_n_e = 1'b0; else rd_n_e = 1'b1;
        tick(2);
        cs_n = 1'b1;
        tick(2);
        check(!bus_oe, tag, bus_oe, 0);
        tick(6);
        drained("R12 read gives no word");
    endtask

    // send n serial bits MSB first; optionally expect a word at the last edge
    task automatic ser_bits(input int n, input logic [8:0] bits, input bit push, input logic [16:0] e);
        for (int i = n - 1; i >= 0; i--) begin
            bus_in = {8'(i * 37 + 11), bits[i], 1'b0, 6'(i * 5 + 3)};
            tick(3);
            if (push && i == 0) exp_q.push_back(e);
            bus_in[6] = 1'b1;
            tick(3);
        end
        bus_in[6] = 1'b0;
    endtask

    task automatic ser_write(input logic flag, input logic [7:0] b, input string tag);
        cs_n = 1'b0;
        rs = strap_ser4 ? flag : !flag;
        tick(2);
        if (strap_ser4) ser_bits(8, {1'b0, b}, 1, {flag, 8'h00, b});
        else            ser_bits(9, {flag, b}, 1, {flag, 8'h00, b});
        tick(2);
        cs_n = 1'b1;
        tick(8);
        drained(tag);
    endtask

    initial begin
        // 8080 style, 16-bit
        do_reset(1, 0, 1, 1);
        wr80(0, 16'h1234, 1, "R2 R5 instruction write");
        wr80(1, 16'hBEEF, 1, "R2 R5 data write");
        wr80(1, 16'h4321, 0, "R4 write while deselected");
        host_read(16'h9A5E, 1, "R10 8080 read");
        host_read(16'h1111, 0, "R4 read while deselected");
        // 8080 style, 8-bit
        do_reset(1, 0, 0, 1);
        wr80(1, 16'h77C6, 1, "R6 narrow 8080");
        // 6800 style, 16-bit then 8-bit
        do_reset(1, 1, 1, 1);
        wr68(1, 16'hCAFE, 1, "R3 R5 6800 data write");
        wr68(0, 16'h0F0F, 1, "R3 R5 6800 instruction write");
        wr68(1, 16'h2222, 0, "R4 6800 deselected");
        host_read(16'h6E6E, 1, "R10 6800 read");
        do_reset(1, 1, 0, 1);
        wr68(0, 16'h1281, 1, "R6 narrow 6800");
        // serial 4-line
        do_reset(0, 0, 1, 1);
        ser_write(1, 8'hA6, "R7 4-line data");
        ser_write(0, 8'h3C, "R7 4-line instruction");
        host_read(16'h7777, 1, "R10 no drive in serial");
        // serial 3-line
        do_reset(0, 0, 1, 0);
        ser_write(1, 8'h5A, "R8 3-line data");
        ser_write(0, 8'hFF, "R8 3-line instruction");
        cs_n = 1'b0;
        tick(2);
        ser_bits(5, 9'h1FF, 0, '0);
        cs_n = 1'b1;
        tick(6);
        drained("R9 aborted frame yields nothing");
        ser_write(0, 8'h81, "R9 frame after abort");
        // deselected serial clocks
        cs_n = 1'b1;
        ser_bits(9, 9'h1AA, 0, '0);
        tick(8);
        drained("R4 serial deselected");
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule